// File: doc/BRIEF.md
# Microcoded Memory Pattern Sequencer

This block runs short programs of control words held in a small internal pattern RAM. A request names a start address and a target bank. The sequencer then fetches one word per clock. Each word decides four things for that cycle: whether transfer acknowledge is raised, whether the pattern ends, whether a bus-monitor timeout may divert execution to the exception pattern, and whether the bank is locked after the pattern finishes.

A timeout arriving while the current word permits it sends the next fetch to a configurable exception start address. Execution continues there until a word marks the end. A finishing word can load a per-bank hold-off counter. While that counter runs, new requests to the same bank wait; requests to other banks proceed at once. A request that waits is kept and is launched as soon as its bank is free.

Top module: `pattern_seq`

## Requirements
- R1: After reset the sequencer is idle: busy_o, word_valid_o, ack_o and done_o are 0, and bank_blocked_o is all zeros.
- R2: A start on an unblocked bank, presented while idle, makes busy_o and word_valid_o high from the next cycle. Consecutive words are executed from start_addr_i, one per cycle. done_o is high only in the cycle of the word whose end flag (bit 0) is set. busy_o falls after that cycle.
- R3: ack_o is high in exactly those busy cycles whose word has the acknowledge bit (bit 1) set.
- R4: If timeout_i is high in a cycle whose word has the exception-enable bit (bit 2) set, and that word is not an end word, the next word fetched is at exc_addr_i. Execution continues from there until an end word. An end word takes precedence over a timeout.
- R5: A timeout in a word whose exception-enable bit is 0 is ignored, and execution continues with the next word. A timeout while idle has no effect.
- R6: A timeout during the exception pattern does not restart it, even if the current word has exception enable set.
- R7: A word with both the hold bit (bit 3) and the end flag set loads its bank's counter with hold_cycles_i. The bank is then reported blocked for hold_cycles_i cycles. The hold bit in a word without the end flag is ignored. A hold of 0 blocks nothing.
- R8: A blocked bank does not delay a start to any other bank.
- R9: A start to a blocked bank is held pending and launches on the first cycle after that bank's blocked indication clears. Starts that arrive while busy or while a request is pending are ignored.
- R10: With wr_en_i high, wr_data_i is written to the pattern RAM at wr_addr_i. Later runs execute the new contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| wr_en_i | input | 1 | Pattern RAM write enable |
| wr_addr_i | input | 6 | Pattern RAM write address |
| wr_data_i | input | 4 | Control word {hold, exc_en, ack, end} |
| start_i | input | 1 | Start request pulse |
| start_addr_i | input | 6 | Pattern start address |
| bank_i | input | 2 | Target bank of the request |
| timeout_i | input | 1 | Bus-monitor timeout |
| exc_addr_i | input | 6 | Exception pattern start address |
| hold_cycles_i | input | 8 | Hold-off period in cycles |
| word_valid_o | output | 1 | A pattern word executes this cycle |
| ack_o | output | 1 | Transfer acknowledge |
| busy_o | output | 1 | Pattern in progress |
| done_o | output | 1 | Final word of the pattern this cycle |
| bank_blocked_o | output | 4 | Per-bank hold-off active |

## Verification
The assertions assume that hold_cycles_i and exc_addr_i stay constant while a pattern runs. They also assume that wr_en_i never writes the word currently being executed. The bench changes configuration and RAM contents only while the sequencer is idle. Start requests are held for a single cycle, timeouts are aligned to chosen word cycles, and every pattern in RAM ends in an end word within a few cycles. As a result, no run depends on a mid-pattern reconfiguration.

// File: rtl/pattern_seq_pkg.sv
package pattern_seq_pkg;
  typedef struct packed {
    logic hold;    // bit 3: load bank hold-off on end
    logic exc_en;  // bit 2: timeout may branch
    logic ack;     // bit 1: transfer acknowledge
    logic last;    // bit 0: end of pattern
  } ctl_word_t;

  localparam int unsigned CTL_W = $bits(ctl_word_t);
endpackage

// File: rtl/pattern_seq_ram.sv
module pattern_seq_ram
  import pattern_seq_pkg::*;
#(
  parameter int unsigned ADDR_W = 6
) (
  input  logic              clk_i,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  ctl_word_t         wr_data_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  output ctl_word_t         rd_word_o
);
  localparam int unsigned DEPTH = 1 << ADDR_W;

  ctl_word_t mem_q [DEPTH];

  always_ff @(posedge clk_i) begin
    if (wr_en_i) mem_q[wr_addr_i] <= wr_data_i;
  end

  assign rd_word_o = mem_q[rd_addr_i];
endmodule

// File: rtl/pattern_seq_hold_timers.sv
module pattern_seq_hold_timers #(
  parameter int unsigned NUM_BANKS = 4,
  parameter int unsigned BANK_W    = 2,
  parameter int unsigned TMR_W     = 8
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 load_i,
  input  logic [BANK_W-1:0]    load_bank_i,
  input  logic [TMR_W-1:0]     period_i,
  output logic [NUM_BANKS-1:0] blocked_o
);
  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    logic [TMR_W-1:0] cnt_q;
    logic             hit;

    assign hit = load_i && (load_bank_i == BANK_W'(b));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)             cnt_q <= '0;
      else if (hit)            cnt_q <= period_i;
      else if (cnt_q != '0)    cnt_q <= cnt_q - TMR_W'(1);
    end

    assign blocked_o[b] = (cnt_q != '0);
  end
endmodule

// File: rtl/pattern_seq_launch.sv
module pattern_seq_launch #(
  parameter int unsigned ADDR_W    = 6,
  parameter int unsigned NUM_BANKS = 4,
  parameter int unsigned BANK_W    = 2
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 start_i,
  input  logic [ADDR_W-1:0]    start_addr_i,
  input  logic [BANK_W-1:0]    bank_i,
  input  logic                 idle_i,
  input  logic [NUM_BANKS-1:0] blocked_i,
  output logic                 launch_o,
  output logic [ADDR_W-1:0]    launch_addr_o,
  output logic [BANK_W-1:0]    launch_bank_o
);
  logic              pend_q;
  logic [ADDR_W-1:0] pend_addr_q;
  logic [BANK_W-1:0] pend_bank_q;
  logic              req_valid;

  assign req_valid     = pend_q | start_i;
  assign launch_addr_o = pend_q ? pend_addr_q : start_addr_i;
  assign launch_bank_o = pend_q ? pend_bank_q : bank_i;
  assign launch_o      = idle_i && req_valid && !blocked_i[launch_bank_o];

  // a request that cannot launch is parked; new starts are dropped meanwhile
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q      <= 1'b0;
      pend_addr_q <= '0;
      pend_bank_q <= '0;
    end else if (launch_o) begin
      pend_q <= 1'b0;
    end else if (idle_i && start_i && !pend_q) begin
      pend_q      <= 1'b1;
      pend_addr_q <= start_addr_i;
      pend_bank_q <= bank_i;
    end
  end
endmodule

// File: rtl/pattern_seq_engine.sv
module pattern_seq_engine
  import pattern_seq_pkg::*;
#(
  parameter int unsigned ADDR_W = 6,
  parameter int unsigned BANK_W = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              launch_i,
  input  logic [ADDR_W-1:0] launch_addr_i,
  input  logic [BANK_W-1:0] launch_bank_i,
  input  ctl_word_t         word_i,
  input  logic              timeout_i,
  input  logic [ADDR_W-1:0] exc_addr_i,
  output logic [ADDR_W-1:0] pc_o,
  output logic [BANK_W-1:0] bank_o,
  output logic              busy_o,
  output logic              ack_o,
  output logic              done_o,
  output logic              hold_load_o
);
  logic              busy_q;
  logic              in_exc_q;
  logic [ADDR_W-1:0] pc_q;
  logic [BANK_W-1:0] bank_q;
  logic              finish;
  logic              branch;

  assign finish = busy_q && word_i.last;
  // end word wins over a timeout; one branch per pattern
  assign branch = busy_q && !word_i.last && timeout_i && word_i.exc_en && !in_exc_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q   <= 1'b0;
      in_exc_q <= 1'b0;
      pc_q     <= '0;
      bank_q   <= '0;
    end else if (launch_i) begin
      busy_q   <= 1'b1;
      in_exc_q <= 1'b0;
      pc_q     <= launch_addr_i;
      bank_q   <= launch_bank_i;
    end else if (busy_q) begin
      if (finish) begin
        busy_q   <= 1'b0;
        in_exc_q <= 1'b0;
      end else if (branch) begin
        pc_q     <= exc_addr_i;
        in_exc_q <= 1'b1;
      end else begin
        pc_q <= pc_q + ADDR_W'(1);
      end
    end
  end

  assign pc_o        = pc_q;
  assign bank_o      = bank_q;
  assign busy_o      = busy_q;
  assign ack_o       = busy_q && word_i.ack;
  assign done_o      = finish;
  assign hold_load_o = finish && word_i.hold;
endmodule

// File: rtl/pattern_seq.sv
module pattern_seq
  import pattern_seq_pkg::*;
#(
  parameter int unsigned ADDR_W    = 6,
  parameter int unsigned NUM_BANKS = 4,
  parameter int unsigned TMR_W     = 8
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 wr_en_i,
  input  logic [ADDR_W-1:0]    wr_addr_i,
  input  logic [3:0]           wr_data_i,
  input  logic                 start_i,
  input  logic [ADDR_W-1:0]    start_addr_i,
  input  logic [$clog2(NUM_BANKS)-1:0] bank_i,
  input  logic                 timeout_i,
  input  logic [ADDR_W-1:0]    exc_addr_i,
  input  logic [TMR_W-1:0]     hold_cycles_i,
  output logic                 word_valid_o,
  output logic                 ack_o,
  output logic                 busy_o,
  output logic                 done_o,
  output logic [NUM_BANKS-1:0] bank_blocked_o
);
  localparam int unsigned BANK_W = $clog2(NUM_BANKS);

  ctl_word_t         cur_word;
  logic [ADDR_W-1:0] pc;
  logic [BANK_W-1:0] cur_bank;
  logic              busy;
  logic              launch;
  logic [ADDR_W-1:0] launch_addr;
  logic [BANK_W-1:0] launch_bank;
  logic              hold_load;

  pattern_seq_ram #(.ADDR_W(ADDR_W)) u_ram (
    .clk_i     (clk_i),
    .wr_en_i   (wr_en_i),
    .wr_addr_i (wr_addr_i),
    .wr_data_i (ctl_word_t'(wr_data_i)),
    .rd_addr_i (pc),
    .rd_word_o (cur_word)
  );

  pattern_seq_launch #(
    .ADDR_W(ADDR_W), .NUM_BANKS(NUM_BANKS), .BANK_W(BANK_W)
  ) u_launch (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .start_i       (start_i),
    .start_addr_i  (start_addr_i),
    .bank_i        (bank_i),
    .idle_i        (!busy),
    .blocked_i     (bank_blocked_o),
    .launch_o      (launch),
    .launch_addr_o (launch_addr),
    .launch_bank_o (launch_bank)
  );

  pattern_seq_engine #(.ADDR_W(ADDR_W), .BANK_W(BANK_W)) u_engine (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .launch_i      (launch),
    .launch_addr_i (launch_addr),
    .launch_bank_i (launch_bank),
    .word_i        (cur_word),
    .timeout_i     (timeout_i),
    .exc_addr_i    (exc_addr_i),
    .pc_o          (pc),
    .bank_o        (cur_bank),
    .busy_o        (busy),
    .ack_o         (ack_o),
    .done_o        (done_o),
    .hold_load_o   (hold_load)
  );

  pattern_seq_hold_timers #(
    .NUM_BANKS(NUM_BANKS), .BANK_W(BANK_W), .TMR_W(TMR_W)
  ) u_timers (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .load_i      (hold_load),
    .load_bank_i (cur_bank),
    .period_i    (hold_cycles_i),
    .blocked_o   (bank_blocked_o)
  );

  assign busy_o       = busy;
  assign word_valid_o = busy;
endmodule

// File: rtl/pattern_seq_chk.sv
module pattern_seq_chk #(
  parameter int unsigned NUM_BANKS = 4,
  parameter int unsigned BANK_W    = 2
) (
  input logic                 clk_i,
  input logic                 rst_ni,
  input logic                 busy_i,
  input logic                 valid_i,
  input logic                 ack_i,
  input logic                 done_i,
  input logic [NUM_BANKS-1:0] blocked_i,
  input logic [BANK_W-1:0]    cur_bank_i
);
  assert_done_then_idle_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_i |=> !busy_i);

  assert_idle_needs_done_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_i) |-> $past(done_i));

  assert_ack_in_word_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_i |-> valid_i);

  assert_block_after_end_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((blocked_i & ~$past(blocked_i)) != '0) |-> $past(done_i));

  assert_one_bank_locks_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(blocked_i & ~$past(blocked_i)) <= 1);

  assert_no_launch_blocked_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_i) |-> !blocked_i[cur_bank_i]);
endmodule

bind pattern_seq pattern_seq_chk #(.NUM_BANKS(NUM_BANKS), .BANK_W(BANK_W)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .busy_i     (busy_o),
  .valid_i    (word_valid_o),
  .ack_i      (ack_o),
  .done_i     (done_o),
  .blocked_i  (bank_blocked_o),
  .cur_bank_i (cur_bank)
);

// File: tb/pattern_seq_tb.sv
module pattern_seq_tb;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       wr_en_i = 1'b0;
  logic [5:0] wr_addr_i = '0;
  logic [3:0] wr_data_i = '0;
  logic       start_i = 1'b0;
  logic [5:0] start_addr_i = '0;
  logic [1:0] bank_i = '0;
  logic       timeout_i = 1'b0;
  logic [5:0] exc_addr_i = 6'd40;
  logic [7:0] hold_cycles_i = '0;
  logic       word_valid_o, ack_o, busy_o, done_o;
  logic [3:0] bank_blocked_o;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  always #10 clk_i = ~clk_i;

  pattern_seq u_dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .wr_en_i(wr_en_i), .wr_addr_i(wr_addr_i),
    .wr_data_i(wr_data_i), .start_i(start_i), .start_addr_i(start_addr_i),
    .bank_i(bank_i), .timeout_i(timeout_i), .exc_addr_i(exc_addr_i),
    .hold_cycles_i(hold_cycles_i), .word_valid_o(word_valid_o), .ack_o(ack_o),
    .busy_o(busy_o), .done_o(done_o), .bank_blocked_o(bank_blocked_o)
  );

  // word encoding {hold, exc_en, ack, end}
  typedef struct packed {
    logic [5:0] addr;
    logic [1:0] bank;
    logic [7:0] to_mask;
    logic [3:0] len;
    logic [3:0] acks;
  } vec_t;

  localparam int NVEC = 7;
  localparam vec_t VECS [NVEC] = '{
    '{6'd0,  2'd0, 8'h00, 4'd4, 4'd3},  // R2 R3 plain run
    '{6'd0,  2'd1, 8'h01, 4'd3, 4'd1},  // R4 branch from word 0
    '{6'd0,  2'd2, 8'h02, 4'd4, 4'd3},  // R5 timeout on word without enable
    '{6'd20, 2'd3, 8'h01, 4'd2, 4'd0},  // R5 enable clear
    '{6'd0,  2'd0, 8'h03, 4'd3, 4'd1},  // R6 timeout in exception word with enable
    '{6'd31, 2'd1, 8'h01, 4'd1, 4'd1},  // R4 end word wins
    '{6'd0,  2'd2, 8'hFF, 4'd3, 4'd1}   // R6 timeout held throughout
  };

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0d exp=%0d", req, act, exp);
    end
  endtask

  task automatic wr_word(input logic [5:0] a, input logic [3:0] d);
    @(negedge clk_i);
    wr_en_i = 1'b1; wr_addr_i = a; wr_data_i = d;
    @(negedge clk_i);
    wr_en_i = 1'b0;
  endtask

  task automatic run_seq(input logic [5:0] a, input logic [1:0] b, input logic [7:0] mask,
                         output int len, output int acks, output int dones, output int done_at);
    len = 0; acks = 0; dones = 0; done_at = -1;
    @(negedge clk_i);
    start_i = 1'b1; start_addr_i = a; bank_i = b;
    @(negedge clk_i);
    start_i = 1'b0;
    for (int i = 0; i < 16; i++) begin
      if (!busy_o) break;
      if (word_valid_o) len++;
      if (ack_o) acks++;
      if (done_o) begin dones++; done_at = i; end
      timeout_i = (i < 8) ? mask[i] : 1'b0;
      @(negedge clk_i);
    end
    timeout_i = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog act=0 exp=1");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int len, acks, dones, done_at;
    int blk, fall_idx, rise_idx, busy_cnt, ack_cnt;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    // R1
    chk(!busy_o && !word_valid_o && !ack_o && !done_o, "R1 idle outputs",
        int'({busy_o, word_valid_o, ack_o, done_o}), 0);
    chk(bank_blocked_o == 4'b0, "R1 blocked", int'(bank_blocked_o), 0);

    // R10 load pattern RAM
    for (int i = 0; i < 64; i++) wr_word(6'(i), 4'h1);
    wr_word(6'd0, 4'h4);
    wr_word(6'd1, 4'h2);
    wr_word(6'd2, 4'h2);
    wr_word(6'd3, 4'h3);
    wr_word(6'd10, 4'h9);
    wr_word(6'd11, 4'hA);
    wr_word(6'd12, 4'h1);
    wr_word(6'd20, 4'h0);
    wr_word(6'd21, 4'h1);
    wr_word(6'd31, 4'h7);
    wr_word(6'd40, 4'h4);
    wr_word(6'd41, 4'h3);

    // R5 timeout while idle
    @(negedge clk_i); timeout_i = 1'b1;
    repeat (2) @(negedge clk_i);
    timeout_i = 1'b0;
    chk(!busy_o, "R5 idle timeout", int'(busy_o), 0);

    for (int v = 0; v < NVEC; v++) begin
      run_seq(VECS[v].addr, VECS[v].bank, VECS[v].to_mask, len, acks, dones, done_at);
      chk(len == int'(VECS[v].len), $sformatf("R2,R4,R5,R6 len vec=%0d", v), len, int'(VECS[v].len));
      chk(acks == int'(VECS[v].acks), $sformatf("R3 acks vec=%0d", v), acks, int'(VECS[v].acks));
      chk(dones == 1 && done_at == len - 1, $sformatf("R2 done vec=%0d", v), done_at, len - 1);
    end

    // R7 R8 R9 hold-off
    hold_cycles_i = 8'd5;
    blk = 0;
    run_seq(6'd10, 2'd1, 8'h00, len, acks, dones, done_at);
    chk(len == 1, "R7 hold pattern len", len, 1);
    chk(bank_blocked_o == 4'b0010, "R7 bank locked", int'(bank_blocked_o), 2);
    if (bank_blocked_o[1]) blk++;
    start_i = 1'b1; start_addr_i = 6'd21; bank_i = 2'd2;
    @(negedge clk_i);
    start_i = 1'b0;
    if (bank_blocked_o[1]) blk++;
    chk(busy_o && bank_blocked_o == 4'b0010, "R8 other bank runs", int'(busy_o), 1);
    @(negedge clk_i);
    if (bank_blocked_o[1]) blk++;
    start_i = 1'b1; start_addr_i = 6'd21; bank_i = 2'd1;
    fall_idx = -1; rise_idx = -1; busy_cnt = 0; ack_cnt = 0;
    @(negedge clk_i);
    start_i = 1'b0;
    for (int i = 0; i < 20; i++) begin
      if (i == 0) begin
        chk(!busy_o, "R9 pending not launched", int'(busy_o), 0);
        start_i = 1'b1; start_addr_i = 6'd0; bank_i = 2'd0;  // dropped
      end else begin
        start_i = 1'b0;
      end
      if (bank_blocked_o[1]) blk++;
      if (!bank_blocked_o[1] && fall_idx < 0) fall_idx = i;
      if (busy_o && rise_idx < 0) rise_idx = i;
      if (busy_o) busy_cnt++;
      if (ack_o) ack_cnt++;
      @(negedge clk_i);
    end
    chk(blk == 5, "R7 hold length", blk, 5);
    chk(rise_idx == fall_idx + 1, "R9 launch after release", rise_idx, fall_idx + 1);
    chk(busy_cnt == 1 && ack_cnt == 0, "R9 extra start ignored", busy_cnt, 1);

    // R7 hold bit without end ignored
    run_seq(6'd11, 2'd3, 8'h00, len, acks, dones, done_at);
    chk(len == 2 && acks == 1, "R7 no-end hold run", len, 2);
    chk(bank_blocked_o == 4'b0, "R7 no-end hold ignored", int'(bank_blocked_o), 0);

    // R7 zero hold
    hold_cycles_i = 8'd0;
    run_seq(6'd10, 2'd0, 8'h00, len, acks, dones, done_at);
    chk(bank_blocked_o == 4'b0, "R7 zero hold", int'(bank_blocked_o), 0);

    // R10 rewrite and rerun
    wr_word(6'd21, 4'h3);
    run_seq(6'd21, 2'd2, 8'h00, len, acks, dones, done_at);
    chk(len == 1 && acks == 1, "R10 rewritten word", acks, 1);

    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule